// File: doc/BRIEF.md
# I/O Bank Auto-Calibration Controller

This block manages calibration for five I/O banks. Each bank has a select bit that says whether it takes part, a supply-good input that may arrive at any time, and a request input for recalibration. After reset the controller opens a fixed timeout window. Every selected bank whose supply is seen gets a calibration. In this model a calibration is a fixed number of cycles. A bank whose supply arrives after the window has closed is still calibrated as soon as the supply is seen, but it is marked late, because such a result may be inaccurate.

User logic reads the per-bank calibration status, the late marks and the per-bank supply status. The supply status stays masked until the global initialization-done input is high. User logic can ask for a recalibration of any selected bank. A request for a bank that is calibrating or that has no supply yet is held, and it runs as soon as the bank can take it. An aggregate flag reports that every selected bank is calibrated. This flag can rise before or after global initialization completes, because it depends only on when the supplies arrive.

Top module: `iocal_ctrl`

## Requirements
- R1: Vector index 0..4 maps to banks 0, 1, 7, 8 and 9, in that order. While reset is high and in the first cycle after it, `cal_done_o`, `late_o`, `vddi_stat_o` and `all_cal_done_o` are all zero.
- R2: `vddi_ok_i` passes through a two-stage synchronizer. If the supply of a selected, idle bank rises before clock edge n+1, its calibration starts at edge n+3 and its `cal_done_o` bit rises at edge n+3+CAL_CYC.
- R3: An unselected bank never calibrates. Its `cal_done_o`, `late_o` and `vddi_stat_o` bits stay 0 whatever its supply does.
- R4: `vddi_stat_o` is a registered copy of select AND synchronized supply. It is forced to 0 while `init_done_i` is low.
- R5: The window lasts WINDOW_CYC cycles after reset. A calibration that starts after the window has closed sets the bank's `late_o` bit. A calibration that starts inside the window leaves `late_o` at 0.
- R6: A selected bank whose supply arrives after the window still calibrates, with the same latency as in R2.
- R7: A request pulse on a calibrated, powered bank clears its `cal_done_o` bit at the next edge. The bit rises again CAL_CYC+1 edges after the request was sampled, and the bank's `late_o` bit is cleared.
- R8: A request that arrives while the bank is calibrating or unpowered is held. A busy bank runs a second full calibration right after the first one, with `cal_done_o` staying 0 in between. An unpowered bank calibrates when its supply comes, with `late_o` at 0.
- R9: `all_cal_done_o` is the registered AND of `cal_done_o` over the selected banks. It is 1 when no bank is selected.
- R10: Requests to an unselected bank are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done_i | input | 1 | Global initialization done; unmasks supply status |
| bank_sel_i | input | 5 | Bank takes part in calibration (static configuration) |
| vddi_ok_i | input | 5 | Asynchronous per-bank supply-good |
| recal_req_i | input | 5 | Per-bank recalibration request pulse |
| cal_done_o | output | 5 | Per-bank calibration complete |
| late_o | output | 5 | Per-bank last calibration started after the window |
| vddi_stat_o | output | 5 | Per-bank supply status, selected banks only |
| all_cal_done_o | output | 1 | All selected banks calibrated |

## Verification
The assertions assume that `bank_sel_i` and `init_done_i` are quasi-static and synchronous to `clk`, and that a recalibration request is a level sampled on a clock edge. Only `vddi_ok_i` is taken to be asynchronous. The stimulus changes the select vector only while reset is held. Supplies are raised and never dropped, and request pulses are driven one cycle wide on the inactive clock edge. Each scenario waits long enough between events that no two banks complete in the same cycle, so the scoreboard queue keeps a single order.

// File: rtl/iocal_pkg.sv
package iocal_pkg;
  typedef enum logic [1:0] {
    BK_WAIT = 2'd0,
    BK_CAL  = 2'd1,
    BK_DONE = 2'd2
  } bank_st_e;
endpackage

// File: rtl/iocal_sync.sv
module iocal_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/iocal_window.sv
module iocal_window #(
  parameter int WINDOW_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  output logic open_o
);
  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q != LIMIT);

  // R5
  win_no_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    !open_o |=> !open_o);
endmodule

// File: rtl/iocal_bank.sv
module iocal_bank
  import iocal_pkg::*;
#(
  parameter int CAL_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sup_i,
  input  logic win_open_i,
  input  logic req_i,
  output logic done_o,
  output logic late_o
);
  localparam int CW = (CAL_CYC > 1) ? $clog2(CAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CAL_CYC - 1);

  bank_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          late_q;
  logic          want;

  assign want = pend_q | req_i;

  always_ff @(posedge clk) begin
    if (rst || !sel_i) begin
      st_q   <= BK_WAIT;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      late_q <= 1'b0;
    end else begin
      case (st_q)
        BK_WAIT: begin
          if (sup_i) begin
            st_q   <= BK_CAL;
            cnt_q  <= '0;
            late_q <= !win_open_i && !want;
            pend_q <= 1'b0;
          end else if (req_i) begin
            pend_q <= 1'b1;
          end
        end
        BK_CAL: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (want) begin
              pend_q <= 1'b0;
              late_q <= 1'b0;
            end else begin
              st_q <= BK_DONE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (req_i) pend_q <= 1'b1;
          end
        end
        BK_DONE: begin
          if (want && sup_i) begin
            st_q   <= BK_CAL;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            late_q <= 1'b0;
          end else if (req_i) begin
            pend_q <= 1'b1;
          end
        end
        default: st_q <= BK_WAIT;
      endcase
    end
  end

  assign done_o = (st_q == BK_DONE);
  assign late_o = late_q;

  // R3
  unsel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> (!done_o && !late_o));

  // R2
  done_after_cal_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(st_q == BK_CAL && cnt_q == LAST));

  // R7
  recal_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i && done_o && sup_i && req_i) |=> (!done_o && !late_o));

  // R8
  pend_no_late_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i && st_q == BK_WAIT && sup_i && want) |=> !late_o);
endmodule

// File: rtl/iocal_ctrl.sv
module iocal_ctrl #(
  parameter int N_BANKS     = 5,
  parameter int WINDOW_CYC  = 5000,
  parameter int CAL_CYC     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_done_i,
  input  logic [N_BANKS-1:0] bank_sel_i,
  input  logic [N_BANKS-1:0] vddi_ok_i,
  input  logic [N_BANKS-1:0] recal_req_i,
  output logic [N_BANKS-1:0] cal_done_o,
  output logic [N_BANKS-1:0] late_o,
  output logic [N_BANKS-1:0] vddi_stat_o,
  output logic               all_cal_done_o
);
  logic [N_BANKS-1:0] sup_s;
  logic               win_open;
  logic [N_BANKS-1:0] done_w;
  logic [N_BANKS-1:0] late_w;
  logic [N_BANKS-1:0] stat_q;
  logic               all_q;

  iocal_sync #(.WIDTH(N_BANKS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (vddi_ok_i),
    .q_o (sup_s)
  );

  iocal_window #(.WINDOW_CYC(WINDOW_CYC)) u_win (
    .clk    (clk),
    .rst    (rst),
    .open_o (win_open)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    iocal_bank #(.CAL_CYC(CAL_CYC)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .sel_i      (bank_sel_i[b]),
      .sup_i      (sup_s[b]),
      .win_open_i (win_open),
      .req_i      (recal_req_i[b]),
      .done_o     (done_w[b]),
      .late_o     (late_w[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      all_q  <= 1'b0;
    end else begin
      stat_q <= bank_sel_i & sup_s & {N_BANKS{init_done_i}};
      all_q  <= &(done_w | ~bank_sel_i);
    end
  end

  assign cal_done_o     = done_w;
  assign late_o         = late_w;
  assign vddi_stat_o    = stat_q;
  assign all_cal_done_o = all_q;

  // R4
  stat_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done_i |=> (vddi_stat_o == '0));

  // R3
  stat_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ((vddi_stat_o & ~bank_sel_i) == '0) || !$stable(bank_sel_i));

  // R9
  all_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((cal_done_o | ~bank_sel_i) != '1) |=> !all_cal_done_o);
endmodule

// File: tb/tb_iocal_ctrl.sv
module tb_iocal_ctrl;
  localparam int N   = 5;
  localparam int WIN = 200;
  localparam int CAL = 12;

  typedef struct { int bank; int cyc; bit late; } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_done = 1'b0;
  logic [N-1:0] sel = '0, vddi = '0, req = '0;
  logic [N-1:0] cal_done, late, vstat;
  logic all_done;

  int cyc = 0, n_cmp = 0, n_bad = 0, rst_cyc = 0;
  exp_t sb[$];
  logic [N-1:0] prev_done = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iocal_ctrl #(.N_BANKS(N), .WINDOW_CYC(WIN), .CAL_CYC(CAL), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .init_done_i(init_done), .bank_sel_i(sel),
    .vddi_ok_i(vddi), .recal_req_i(req), .cal_done_o(cal_done),
    .late_o(late), .vddi_stat_o(vstat), .all_cal_done_o(all_done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(int b, int c, bit l);
    exp_t e;
    e.bank = b; e.cyc = c; e.late = l;
    sb.push_back(e);
  endtask

  task automatic waitn(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse(int b);
    req[b] = 1'b1;
    @(negedge clk);
    req = '0;
  endtask

  // monitor: every rising completion is popped and compared
  always @(negedge clk) begin
    if (!rst) begin
      for (int b = 0; b < N; b++) begin
        if (cal_done[b] && !prev_done[b]) begin
          if (sb.size() == 0) begin
            chk("R2 unexpected completion bank", b, 99);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk("R2 completion bank", b, e.bank);
            chk("R2 completion cycle", cyc, e.cyc);
            chk("R5 late at completion", late[b], e.late);
          end
        end
      end
    end
    prev_done = rst ? '0 : cal_done;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    sel = 5'b10111;
    waitn(3);
    rst = 1'b0;
    rst_cyc = cyc;
    // R1 reset state
    chk("R1 cal_done reset", cal_done, 0);
    chk("R1 late reset", late, 0);
    chk("R1 vddi_stat reset", vstat, 0);
    chk("R1 all_done reset", all_done, 0);
    waitn(2);
    // R2: bank index 0 (bank 0) powered inside window
    vddi[0] = 1'b1; push(0, cyc + 3 + CAL, 0);
    waitn(5);
    chk("R4 status masked before init", vstat, 0);
    init_done = 1'b1;
    waitn(2);
    chk("R4 status after init", vstat, 5'b00001);
    // R3: index 3 (bank 8) unselected; index 1 (bank 1) powered
    vddi[3] = 1'b1; vddi[1] = 1'b1; push(1, cyc + 3 + CAL, 0);
    waitn(CAL + 10);
    chk("R3 unselected status", vstat, 5'b00011);
    chk("R3 unselected no cal", cal_done, 5'b00011);
    chk("R9 all_done pending banks", all_done, 0);
    // R6/R5: index 2 (bank 7) powered after the window
    while (cyc < rst_cyc + WIN + 20) @(negedge clk);
    vddi[2] = 1'b1; push(2, cyc + 3 + CAL, 1);
    waitn(CAL + 6);
    chk("R5 late flag", late, 5'b00100);
    chk("R6 late bank calibrated", cal_done, 5'b00111);
    // R8: request held while index 4 (bank 9) unpowered
    pulse(4);
    waitn(20);
    chk("R8 unpowered held", cal_done[4], 0);
    vddi[4] = 1'b1; push(4, cyc + 3 + CAL, 0);
    waitn(CAL + 5);
    chk("R9 all selected done", all_done, 1);
    chk("R8 pending cleared late", late[4], 0);
    // R7: recalibrate late bank index 2
    begin
      int n0;
      n0 = cyc;
      push(2, n0 + 1 + CAL, 0);
      pulse(2);
      chk("R7 done cleared", cal_done[2], 0);
      chk("R7 late cleared", late[2], 0);
      chk("R9 all_done follows", all_done, 1);
      waitn(1);
      chk("R9 all_done drops", all_done, 0);
    end
    waitn(CAL + 3);
    chk("R7 recal complete", cal_done[2], 1);
    // R8: request while busy on index 1
    begin
      int n1;
      n1 = cyc;
      push(1, n1 + 1 + 2 * CAL, 0);
      pulse(1);
      waitn(2);
      pulse(1);
      while (cyc < n1 + 1 + CAL + 2) @(negedge clk);
      chk("R8 busy rerun keeps done low", cal_done[1], 0);
    end
    waitn(CAL + 4);
    chk("R8 busy rerun done", cal_done[1], 1);
    // R10: request to unselected index 3
    pulse(3);
    waitn(CAL + 5);
    chk("R10 unselected request ignored", cal_done[3], 0);
    chk("R10 unselected status", vstat[3], 0);
    chk("R9 all_done restored", all_done, 1);
    // R9: no bank selected
    rst = 1'b1; sel = '0;
    waitn(3);
    rst = 1'b0;
    waitn(3);
    chk("R9 empty selection", all_done, 1);
    chk("R3 empty selection status", vstat, 0);
    chk("R2 scoreboard drained", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule